// File: doc/BRIEF.md
# Word-Interleaved Memory Block Fetcher

This block fills one cache block from a main memory made of several banks. Words are spread so that word address `w` lives in bank `w mod NUM_BANKS`, at row `w / NUM_BANKS`. A fill starts with a one-word-wide request that carries only a block address. The fetcher drives that address once to every bank, lets all banks perform their access at the same time, and then streams the block's words back one per cycle on a one-word bus. Each word comes with a valid strobe and its index inside the block. A one-cycle completion pulse follows the last word.

The banks are built inside the block. Each bank is a small array with a programmable access latency and is loaded through a plain word write port. A build-time mode switch replaces the interleaved banks with one bank that holds every word. In that mode each word of a fill pays its own address, access and transfer cycles, which gives a baseline for comparing the two organisations. Only one fill is in flight at a time. The caller starts a fill while `idle` is high.

With the default settings (4 banks, 6-cycle access, 1-cycle address and 1-cycle transfer), an interleaved fill occupies 11 cycles. The sequential baseline occupies 32 cycles.

Top module: `ilv_block_fetch`

## Requirements
- R1: While reset is asserted, and right after it is released, `idle` is 1 and both `word_valid` and `fill_done` are 0.
- R2: In interleaved mode, a request is accepted on a clock edge where `idle` and `req_valid` are both 1. The first word is valid in the 7th cycle after that edge, that is, after 1 address cycle and ACCESS_CYC=6 access cycles. The remaining words follow on consecutive cycles, so the whole transfer ends 11 cycles after acceptance.
- R3: Words come out in index order 0, 1, 2, 3 on `word_idx`. The word with index i carries the data stored at word address `req_blk*NUM_BANKS + i`. The bank is selected by the low 2 bits of the word address, and the row is given by the remaining upper bits.
- R4: `fill_done` is a single-cycle pulse in the cycle right after the word with index 3. `idle` returns to 1 in the cycle after `fill_done`.
- R5: In sequential mode (INTERLEAVE=0), word i is valid in cycle 7+8i after acceptance. `fill_done` comes at cycle 32, and `idle` returns at cycle 33.
- R6: A request raised while `idle` is 0 has no effect. The running fill returns its own block unchanged, and no second fill starts afterwards.
- R7: A write on the write port stores `wr_data` at word address `wr_addr`. Any later fill that covers that address returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fill request, taken only while idle |
| req_blk | input | BLK_W (4) | Block address of the fill |
| idle | output | 1 | Fetcher can accept a request |
| wr_en | input | 1 | Bank write strobe |
| wr_addr | input | BLK_W+log2(NUM_BANKS) (6) | Word address to write |
| wr_data | input | WORD_W (32) | Word to store |
| word_valid | output | 1 | A block word is on `word_data` |
| word_idx | output | log2(NUM_BANKS) (2) | Index of that word inside the block |
| word_data | output | WORD_W (32) | Returned word |
| fill_done | output | 1 | One-cycle pulse after the last word |

## Verification
A sequencer stuck in the wrong state, or a bank counter that is off by one, moves the valid strobe away from its expected cycle. This is visible on the first word, seven cycles after acceptance. A wrong word counter or a wrong bank select gives a wrong index or wrong data in the same cycle the bad word is driven. A fetcher that takes a request while busy shows itself later: it returns words of the wrong block, or it emits extra strobes after `fill_done`. The bench watches a window long enough to catch these stray strobes.

// File: rtl/ilv_pkg.sv
`timescale 1ns/1ps
package ilv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACCESS,
    ST_XFER,
    ST_DONE
  } fetch_state_e;
endpackage

// File: rtl/ilv_bank.sv
`timescale 1ns/1ps
// One memory bank: storage array plus an access-latency counter.
// A start pulse latches the row; the word lands in the output register
// exactly ACCESS_CYC edges later, announced one cycle ahead by rd_last.
module ilv_bank #(
  parameter int WORD_W     = 32,
  parameter int ROW_W      = 4,
  parameter int ACCESS_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              start,
  input  logic [ROW_W-1:0]  rd_row,
  output logic              rd_last,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ROW_W;
  localparam int CNT_W = $clog2(ACCESS_CYC + 1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic              load_en;

  always_comb begin
    cnt_d   = cnt_q;
    row_d   = row_q;
    load_en = (cnt_q == CNT_W'(1));
    if (start) begin
      cnt_d = CNT_W'(ACCESS_CYC);
      row_d = rd_row;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
    data_d = load_en ? mem_q[row_q] : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      row_q  <= '0;
      data_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      row_q  <= row_d;
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_row] <= wr_data;
    end
  end

  assign rd_last = load_en;
  assign rd_data = data_q;
endmodule

// File: rtl/ilv_seq.sv
`timescale 1ns/1ps
// Fill sequencer: address, access, transfer, done.
// Interleaved: one access phase, then all words back to back.
// Sequential: the address/access/transfer loop repeats per word.
module ilv_seq #(
  parameter int NUM_WORDS  = 4,
  parameter int INTERLEAVE = 1,
  localparam int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             access_last,
  output logic             idle,
  output logic             accept,
  output logic             bank_start,
  output logic             word_valid,
  output logic [IDX_W-1:0] word_idx,
  output logic             fill_done
);
  import ilv_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  fetch_state_e     state_q, state_d;
  logic [IDX_W-1:0] widx_q, widx_d;

  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d = state_q;
    widx_d  = widx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_ADDR;
          widx_d  = '0;
        end
      end
      ST_ADDR:   state_d = ST_ACCESS;
      ST_ACCESS: begin
        if (access_last) state_d = ST_XFER;
      end
      ST_XFER: begin
        if (widx_q == LAST_IDX) begin
          state_d = ST_DONE;
        end else begin
          widx_d = widx_q + IDX_W'(1);
          if (INTERLEAVE == 0) state_d = ST_ADDR;
        end
      end
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      widx_q  <= '0;
    end else begin
      state_q <= state_d;
      widx_q  <= widx_d;
    end
  end

  assign idle       = (state_q == ST_IDLE);
  assign bank_start = (state_q == ST_ADDR);
  assign word_valid = (state_q == ST_XFER);
  assign word_idx   = widx_q;
  assign fill_done  = (state_q == ST_DONE);
endmodule

// File: rtl/ilv_block_fetch.sv
`timescale 1ns/1ps
// Top: block-fill fetcher over word-interleaved (or single) banks.
module ilv_block_fetch #(
  parameter int WORD_W     = 32,
  parameter int NUM_BANKS  = 4,
  parameter int BLK_W      = 4,
  parameter int ACCESS_CYC = 6,
  parameter int INTERLEAVE = 1,
  localparam int IDX_W     = $clog2(NUM_BANKS),
  localparam int WADDR_W   = BLK_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [BLK_W-1:0]   req_blk,
  output logic               idle,
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  output logic               word_valid,
  output logic [IDX_W-1:0]   word_idx,
  output logic [WORD_W-1:0]  word_data,
  output logic               fill_done
);
  logic             accept;
  logic             bank_start;
  logic             access_last;
  logic [BLK_W-1:0] blk_q, blk_d;

  always_comb begin
    blk_d = blk_q;
    if (accept) blk_d = req_blk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_q <= '0;
    else        blk_q <= blk_d;
  end

  ilv_seq #(
    .NUM_WORDS  (NUM_BANKS),
    .INTERLEAVE (INTERLEAVE)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .access_last (access_last),
    .idle        (idle),
    .accept      (accept),
    .bank_start  (bank_start),
    .word_valid  (word_valid),
    .word_idx    (word_idx),
    .fill_done   (fill_done)
  );

  if (INTERLEAVE != 0) begin : g_ilv
    logic [NUM_BANKS-1:0] last_v;
    logic [WORD_W-1:0]    data_v [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic bank_wr;
      assign bank_wr = wr_en && (wr_addr[IDX_W-1:0] == IDX_W'(b));
      ilv_bank #(
        .WORD_W     (WORD_W),
        .ROW_W      (BLK_W),
        .ACCESS_CYC (ACCESS_CYC)
      ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_wr),
        .wr_row  (wr_addr[WADDR_W-1:IDX_W]),
        .wr_data (wr_data),
        .start   (bank_start),
        .rd_row  (blk_q),
        .rd_last (last_v[b]),
        .rd_data (data_v[b])
      );
    end

    assign access_last = &last_v;
    assign word_data   = data_v[word_idx];
  end else begin : g_single
    logic              last_s;
    logic [WORD_W-1:0] data_s;

    ilv_bank #(
      .WORD_W     (WORD_W),
      .ROW_W      (WADDR_W),
      .ACCESS_CYC (ACCESS_CYC)
    ) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_row  (wr_addr),
      .wr_data (wr_data),
      .start   (bank_start),
      .rd_row  ({blk_q, word_idx}),
      .rd_last (last_s),
      .rd_data (data_s)
    );

    assign access_last = last_s;
    assign word_data   = data_s;
  end
endmodule

// File: rtl/ilv_block_fetch_chk.sv
`timescale 1ns/1ps
module ilv_block_fetch_chk #(
  parameter int IDX_W      = 2,
  parameter int NUM_WORDS  = 4,
  parameter int ACCESS_CYC = 6,
  parameter int INTERLEAVE = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             idle,
  input logic             word_valid,
  input logic [IDX_W-1:0] word_idx,
  input logic             fill_done
);
  localparam int STEP = (INTERLEAVE != 0) ? 1 : (ACCESS_CYC + 2);
  localparam int SPAN = 1 + ACCESS_CYC + STEP * (NUM_WORDS - 1) + 4;
  localparam int CW   = $clog2(SPAN + 1) + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic [CW-1:0] cyc_q;
  logic [CW-1:0] exp_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cyc_q <= '1;
    else if (idle && req_valid)  cyc_q <= '0;
    else if (cyc_q != '1)        cyc_q <= cyc_q + CW'(1);
  end

  assign exp_cyc = CW'(1 + ACCESS_CYC) + CW'(word_idx) * CW'(STEP);

  // R2 and R5: each word appears at its fixed distance from acceptance
  assert_word_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (cyc_q == exp_cyc));

  assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $past(word_valid)) |-> (word_idx == $past(word_idx) + IDX_W'(1)));

  assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> ($past(word_valid) && ($past(word_idx) == LAST_IDX)));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (!fill_done && idle));

  assert_accept_idle_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> $past(req_valid));

  assert_busy_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !idle);
endmodule

bind ilv_block_fetch ilv_block_fetch_chk #(
  .IDX_W      (IDX_W),
  .NUM_WORDS  (NUM_BANKS),
  .ACCESS_CYC (ACCESS_CYC),
  .INTERLEAVE (INTERLEAVE)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .idle       (idle),
  .word_valid (word_valid),
  .word_idx   (word_idx),
  .fill_done  (fill_done)
);

// File: tb/ilv_block_fetch_tb_top.sv
`timescale 1ns/1ps
module ilv_block_fetch_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_blk;
  logic        wr_en;
  logic [5:0]  wr_addr;
  logic [31:0] wr_data;

  logic        i_idle, i_valid, i_done;
  logic [1:0]  i_idx;
  logic [31:0] i_data;
  logic        s_idle, s_valid, s_done;
  logic [1:0]  s_idx;
  logic [31:0] s_data;

  logic [31:0] exp_mem [64];
  int n_chk;
  int n_bad;
  bit finished;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  ilv_block_fetch #(.INTERLEAVE(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
    .idle(i_idle), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .word_valid(i_valid), .word_idx(i_idx), .word_data(i_data), .fill_done(i_done)
  );

  ilv_block_fetch #(.INTERLEAVE(0)) dut_seq_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
    .idle(s_idle), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .word_valid(s_valid), .word_idx(s_idx), .word_data(s_data), .fill_done(s_done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input int a);
    return {8'hC3, 8'(a), 16'(a * a + 7)};
  endfunction

  task automatic write_word(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
    exp_mem[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // One fill on both instances, checked cycle by cycle after the accepting edge.
  task automatic run_fill(input logic [3:0] blk, input bit poke, input string ovr);
    string ti, ts, td;
    @(negedge clk);
    check("R2 idle before request (interleaved)", 32'(i_idle), 32'd1);
    check("R5 idle before request (sequential)", 32'(s_idle), 32'd1);
    req_valid = 1'b1; req_blk = blk;
    @(posedge clk);
    for (int k = 0; k <= 40; k++) begin
      bit ev_i, ev_s;
      int ix_i, ix_s;
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      if (poke && k == 3) begin req_valid = 1'b1; req_blk = blk ^ 4'h9; end
      if (poke && k == 4) req_valid = 1'b0;
      ti = (ovr != "") ? ovr : "R2";
      ts = (ovr != "") ? ovr : "R5";
      td = (ovr != "") ? ovr : "R3";
      ev_i = (k >= 7) && (k <= 10);
      ix_i = k - 7;
      ev_s = (k >= 7) && (k <= 31) && (((k - 7) % 8) == 0);
      ix_s = (k - 7) / 8;
      check({ti, " interleaved word_valid"}, 32'(i_valid), 32'(ev_i));
      check({(ovr != "") ? ovr : "R4", " interleaved fill_done"}, 32'(i_done), 32'(k == 11));
      check({(ovr != "") ? ovr : "R4", " interleaved idle"}, 32'(i_idle), 32'(k >= 12));
      if (ev_i) begin
        check({td, " interleaved word_idx"}, 32'(i_idx), 32'(ix_i));
        check({td, " interleaved word_data"}, i_data, exp_mem[int'(blk) * 4 + ix_i]);
      end
      check({ts, " sequential word_valid"}, 32'(s_valid), 32'(ev_s));
      check({ts, " sequential fill_done"}, 32'(s_done), 32'(k == 32));
      check({ts, " sequential idle"}, 32'(s_idle), 32'(k >= 33));
      if (ev_s) begin
        check({ts, " sequential word_idx"}, 32'(s_idx), 32'(ix_s));
        check({(ovr != "") ? ovr : "R5", " sequential word_data"}, s_data,
              exp_mem[int'(blk) * 4 + ix_s]);
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; req_blk = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    check("R1 idle in reset", 32'(i_idle & s_idle), 32'd1);
    check("R1 word_valid in reset", 32'(i_valid | s_valid), 32'd0);
    check("R1 fill_done in reset", 32'(i_done | s_done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 32'(i_idle & s_idle), 32'd1);
    check("R1 word_valid after reset", 32'(i_valid | s_valid), 32'd0);
  endtask

  task automatic t_preload;
    for (int a = 0; a < 64; a++) write_word(a, pattern(a));
  endtask

  task automatic t_fills;
    run_fill(4'd0, 1'b0, "");
    run_fill(4'd5, 1'b0, "");
    run_fill(4'd15, 1'b0, "");
  endtask

  task automatic t_busy_request;
    run_fill(4'd2, 1'b1, "R6");
  endtask

  task automatic t_write_update;
    write_word(7 * 4 + 2, 32'hDEAD_BEEF);
    write_word(7 * 4 + 0, 32'h0BAD_F00D);
    run_fill(4'd7, 1'b0, "R7");
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    t_reset();
    t_preload();
    t_fills();
    t_busy_request();
    t_write_update();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule